// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block carries out a single configuration write into a physical-layer macro through its strobe-driven test port. A requester offers an 8-bit test code together with an 8-bit data byte; once the offer is taken, the sequencer plays out a fixed waveform on four test pins: a clear line, a strobe (test clock), an enable line, and an 8-bit bus. While the enable line is high the bus carries the code, which the PHY latches on the strobe's falling edge. While enable is low the bus carries data, which the PHY latches on the strobe's rising edge.

The waveform has six steps, and each step holds for `PHASE_CYC` clock cycles so that the PHY always sees stable setup and hold. The steps run in this order:
1. A clear pulse.
2. A quiet step with everything low.
3. The strobe goes high.
4. The code step: enable high, strobe falling.
5. The data step: enable low, strobe rising.
6. A tail step that returns the strobe low while the data byte stays on the bus.

The request side is a valid/ready handshake. `start_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `start_valid` and `start_ready` are both high. Back-pressure is total: for the whole write `start_ready` stays low, and any request offered in that time is neither taken nor queued. The requester must keep its offer stable until it is taken. `busy` and `done` are plain status pins.

Top module: `phy_tst_wr_seq`

## Requirements
- R1: During reset and whenever idle, `tst_clr`, `tst_clk`, `tst_en`, `tst_bus`, `busy` and `done` are all 0 and `start_ready` is 1.
- R2: For the `PHASE_CYC` cycles that begin one cycle after acceptance, `tst_clr`=1 while `tst_clk`, `tst_en` and `tst_bus` are 0.
- R3: After the clear step, all four test outputs are 0 for `PHASE_CYC` cycles. Then `tst_clk`=1 with `tst_en`=0 and `tst_bus`=0 for `PHASE_CYC` cycles.
- R4: Code step: `tst_en`=1, `tst_bus`=code and `tst_clk`=0 for `PHASE_CYC` cycles. The strobe falls in the same cycle that enable rises.
- R5: Data step: `tst_en`=0, `tst_bus`=data and `tst_clk`=1 for `PHASE_CYC` cycles. The strobe rises in the same cycle that enable falls.
- R6: Tail step: `tst_clk`=0, `tst_en`=0, `tst_clr`=0 and `tst_bus` still equal to data, for `PHASE_CYC` cycles. After the tail, the bus returns to 0.
- R7: `busy` is 1 for exactly 6×`PHASE_CYC` cycles. It is followed by a one-cycle `done` pulse in which `start_ready` is 1, so a new request can be taken in that same cycle.
- R8: While `busy` is 1, `start_ready` is 0 and an offered request has no effect on the current write. Code and data are captured at acceptance, so later changes on `start_code` and `start_data` are ignored.
- R9: Asserting reset in the middle of a write drives all test outputs to 0 and returns the sequencer to idle, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Write request offered |
| start_ready | output | 1 | Sequencer idle; request can be taken |
| start_code | input | BUS_W | Test code for the request |
| start_data | input | BUS_W | Data byte for the request |
| busy | output | 1 | Write waveform in progress |
| done | output | 1 | One-cycle pulse after the final step |
| tst_clr | output | 1 | Test-port clear line |
| tst_clk | output | 1 | Test-port strobe |
| tst_en | output | 1 | High: bus holds a code; low: bus holds data |
| tst_bus | output | BUS_W | Test-port code/data bus |

## Verification
The bench instantiates the block with `PHASE_CYC`=3 and `BUS_W`=8. Three cycles per step is enough to show that every step holds across several cycles and that the step counter wraps correctly, rather than advancing every cycle as it would at the minimum value of 1. Eight-bit codes and data are driven with all-ones, all-zeros and alternating patterns, so a swapped or stuck bus bit appears in a specific step. Further tests cover:
- a request taken in the `done` cycle, giving back-to-back writes;
- requests offered while `busy` is high;
- a reset asserted in the middle of a write.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_QUIET  = 3'd2,
    ST_RISE   = 3'd3,
    ST_CODE   = 3'd4,
    ST_DATA   = 3'd5,
    ST_TAIL   = 3'd6
  } step_e;

  localparam int unsigned NUM_STEPS = 6;

  function automatic step_e step_after(input step_e s);
    case (s)
      ST_CLEAR: return ST_QUIET;
      ST_QUIET: return ST_RISE;
      ST_RISE:  return ST_CODE;
      ST_CODE:  return ST_DATA;
      ST_DATA:  return ST_TAIL;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/phy_tst_step_timer.sv
module phy_tst_step_timer #(
  parameter int unsigned PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic last
);
  localparam int unsigned CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == CNT_TOP);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP); // R7

  initial begin
    AST_PHASE_NONZERO: assert (PHASE_CYC >= 1); // R7
  end
endmodule

// File: rtl/phy_tst_pin_drv.sv
module phy_tst_pin_drv
  import phy_tst_pkg::*;
#(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step_nxt,
  input  logic [BUS_W-1:0] code_val,
  input  logic [BUS_W-1:0] data_val,
  output logic             tst_clr,
  output logic             tst_clk,
  output logic             tst_en,
  output logic [BUS_W-1:0] tst_bus
);
  logic             clr_d, clk_d, en_d;
  logic [BUS_W-1:0] bus_d;

  always_comb begin
    clr_d = 1'b0;
    clk_d = 1'b0;
    en_d  = 1'b0;
    bus_d = '0;
    case (step_nxt)
      ST_CLEAR: clr_d = 1'b1;
      ST_RISE:  clk_d = 1'b1;
      ST_CODE: begin
        en_d  = 1'b1;
        bus_d = code_val;
      end
      ST_DATA: begin
        clk_d = 1'b1;
        bus_d = data_val;
      end
      ST_TAIL:  bus_d = data_val;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tst_clr <= 1'b0;
      tst_clk <= 1'b0;
      tst_en  <= 1'b0;
      tst_bus <= '0;
    end else begin
      tst_clr <= clr_d;
      tst_clk <= clk_d;
      tst_en  <= en_d;
      tst_bus <= bus_d;
    end
  end

  AST_CLR_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    tst_clr |-> (!tst_clk && !tst_en && tst_bus == '0)); // R2
  AST_EN_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tst_en |-> !tst_clk); // R4
  AST_CODE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_en) |-> $fell(tst_clk)); // R4
  AST_DATA_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_en) |-> $rose(tst_clk)); // R5
endmodule

// File: rtl/phy_tst_wr_seq.sv
module phy_tst_wr_seq
  import phy_tst_pkg::*;
#(
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned PHASE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [BUS_W-1:0] start_code,
  input  logic [BUS_W-1:0] start_data,
  output logic             busy,
  output logic             done,
  output logic             tst_clr,
  output logic             tst_clk,
  output logic             tst_en,
  output logic [BUS_W-1:0] tst_bus
);
  step_e            step_q, step_d;
  logic             take, step_last, advance, done_q;
  logic [BUS_W-1:0] code_q, data_q;

  assign start_ready = (step_q == ST_IDLE);
  assign busy        = (step_q != ST_IDLE);
  assign done        = done_q;
  assign take        = start_valid && start_ready;
  assign advance     = take || (busy && step_last);

  always_comb begin
    step_d = step_q;
    if (take)                   step_d = ST_CLEAR;
    else if (busy && step_last) step_d = step_after(step_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
      code_q <= '0;
      data_q <= '0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_TAIL) && step_last;
      if (take) begin
        code_q <= start_code;
        data_q <= start_data;
      end
    end
  end

  phy_tst_step_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (advance),
    .run     (busy),
    .last    (step_last)
  );

  phy_tst_pin_drv #(.BUS_W(BUS_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_nxt (step_d),
    .code_val (code_q),
    .data_val (data_q),
    .tst_clr  (tst_clr),
    .tst_clk  (tst_clk),
    .tst_en   (tst_en),
    .tst_bus  (tst_bus)
  );

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_valid) |=> ($stable(code_q) && $stable(data_q))); // R8
  AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tst_clr && !tst_clk && !tst_en && tst_bus == '0)); // R1
endmodule

// File: tb/tb_phy_tst_wr_seq.sv
module tb_phy_tst_wr_seq;
  localparam int unsigned BW = 8;
  localparam int unsigned P  = 3;

  typedef struct {
    logic [BW+5:0] v;   // {ready,busy,done,clr,clk,en,bus}
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start_valid = 1'b0;
  logic [BW-1:0] start_code = '0, start_data = '0;
  logic start_ready, busy, done, tst_clr, tst_clk, tst_en;
  logic [BW-1:0] tst_bus;

  int total = 0, bad = 0;
  bit mon_en = 1'b0, finished = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  phy_tst_wr_seq #(.BUS_W(BW), .PHASE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_code(start_code), .start_data(start_data), .busy(busy), .done(done),
    .tst_clr(tst_clr), .tst_clk(tst_clk), .tst_en(tst_en), .tst_bus(tst_bus));

  function automatic logic [BW+5:0] pk(logic r, logic b, logic d, logic c,
                                       logic k, logic e, logic [BW-1:0] v);
    return {r, b, d, c, k, e, v};
  endfunction

  task automatic chk(string tag, logic [BW+5:0] act, logic [BW+5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [BW+5:0] now_pins();
    return pk(start_ready, busy, done, tst_clr, tst_clk, tst_en, tst_bus);
  endfunction

  task automatic push_one(logic [BW+5:0] v, string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Expected waveform for one accepted write
  task automatic push_write(logic [BW-1:0] c, logic [BW-1:0] d);
    for (int i = 0; i < P; i++) push_one(pk(0, 1, 0, 1, 0, 0, '0), "R2 clear");
    for (int i = 0; i < P; i++) push_one(pk(0, 1, 0, 0, 0, 0, '0), "R3 quiet");
    for (int i = 0; i < P; i++) push_one(pk(0, 1, 0, 0, 1, 0, '0), "R3 rise");
    for (int i = 0; i < P; i++) push_one(pk(0, 1, 0, 0, 0, 1, c),  "R4 code");
    for (int i = 0; i < P; i++) push_one(pk(0, 1, 0, 0, 1, 0, d),  "R5 data");
    for (int i = 0; i < P; i++) push_one(pk(0, 1, 0, 0, 0, 0, d),  "R6 tail");
    push_one(pk(1, 0, 1, 0, 0, 0, '0), "R7 done");
  endtask

  // Monitor: compares against the scoreboard queue, idle checks otherwise
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (busy || done) begin
        if (q.size() == 0) chk("R8 unexpected activity", now_pins(), '0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, now_pins(), e.v);
        end
      end else begin
        chk("R1 idle", now_pins(), pk(1, 0, 0, 0, 0, 0, '0));
      end
    end
  end

  task automatic issue(logic [BW-1:0] c, logic [BW-1:0] d);
    @(negedge clk);
    while (!start_ready) @(negedge clk);
    start_valid = 1'b1;
    start_code  = c;
    start_data  = d;
    push_write(c, d);
    @(negedge clk);
    start_valid = 1'b0;
    start_code  = ~c;   // R8: later changes must not leak into the write
    start_data  = ~d;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", now_pins(), pk(1, 0, 0, 0, 0, 0, '0));
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (2) @(negedge clk);

    issue(8'h44, 8'h2a); drain();
    issue(8'hff, 8'h00); drain();
    issue(8'h00, 8'hff); drain();

    // R7 back-to-back: second request taken in the done cycle
    issue(8'ha5, 8'h5a);
    issue(8'h3c, 8'hc3);
    drain();

    // R8 request offered while busy
    issue(8'h81, 8'h7e);
    repeat (2) @(negedge clk);
    start_valid = 1'b1; start_code = 8'h11; start_data = 8'h22;
    repeat (3) @(negedge clk);
    start_valid = 1'b0;
    drain();

    // R9 reset in the middle of a write
    issue(8'h96, 8'h69);
    repeat (10) @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    q.delete();
    @(negedge clk);
    chk("R9 reset mid write", now_pins(), pk(1, 0, 0, 0, 0, 0, '0));
    rst_n  = 1'b1;
    mon_en = 1'b1;
    repeat (6 * P + 4) @(negedge clk);   // idle checks: no done, no resumed write
    issue(8'h5f, 8'hf5); drain();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule